// File: doc/BRIEF.md
# Burst Address Sequencer for Synchronous SRAM

This block produces the four addresses of one burst access to a synchronous burst SRAM. A load strobe captures a full start address. Each advance strobe then moves the burst on by one beat. Only the two lowest address bits change from beat to beat, and the bits above them hold the value captured at load.

Two beat orders are supported. The linear order counts upward from the start and wraps modulo four. The interleaved order, as processor caches expect, forms each beat by XOR-ing the start bits with the beat number. The order is captured together with the start address, so a burst always finishes in the order it began with.

The load and advance strobes, the mode select and the burst-last flag are plain control pins. The address output is a registered state value that holds until the next strobe, so it needs no back-pressure handshake.

Top module: `burst_addr_seq`

## Requirements
- R1: After synchronous reset, addr_o is all zeros and last_o is low.
- R2: A load captures start_addr_i, and addr_o equals it in the cycle after the load edge (beat number zero).
- R3: The address bits above the two beat bits stay equal to the loaded value until the next load.
- R4: With mode_i = 0 at load (linear), the low two bits of beat k are (start + k) mod 4, for example 01, 10, 11, 00.
- R5: With mode_i = 1 at load (interleaved), the low two bits of beat k are start XOR k, for example 01, 00, 11, 10.
- R6: A start of 00 gives the order 00, 01, 10, 11 in both modes.
- R7: Each cycle with advance_i high and load_i low moves to the next beat. With both strobes low, addr_o and last_o hold.
- R8: Advancing from the fourth beat wraps the beat number to zero, and addr_o returns to the loaded start address.
- R9: last_o is high exactly while the burst is on its fourth beat (beat number 3).
- R10: mode_i is sampled only on a load. Changing it during a burst has no effect on the remaining beats.
- R11: When load_i and advance_i are high in the same cycle, the load wins and the burst restarts at beat zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Capture start address and mode, restart at beat zero |
| start_addr_i | input | ADDR_W | Burst start address |
| advance_i | input | 1 | Step to the next beat |
| mode_i | input | 1 | Beat order: 0 linear, 1 interleaved |
| addr_o | output | ADDR_W | Address of the current beat |
| last_o | output | 1 | High on the fourth beat |

## Verification
On every cycle, the assertions check the following: the beat counter clears on a load and steps by one on an advance, the upper bits and the captured mode do not move without a load, the address holds when idle, and a wrap from the last beat lands back on the start. The exact beat orders can only be shown by the bench's scenarios, which walk all four starts in both modes. The same applies to the agreement of the two orders at start 00, to mode changes in mid-burst having no effect, and to the load-over-advance priority.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/burst_beat_counter.sv
module burst_beat_counter #(
  parameter int BEAT_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clear_i,
  input  logic                 step_i,
  output logic [BEAT_BITS-1:0] idx_o,
  output logic                 last_o
);
  localparam logic [BEAT_BITS-1:0] LAST_IDX = '1;
  localparam logic [BEAT_BITS-1:0] ONE      = BEAT_BITS'(1);

  logic [BEAT_BITS-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) idx_q <= '0;
    else if (step_i)    idx_q <= idx_q + ONE;
  end

  assign idx_o  = idx_q;
  assign last_o = (idx_q == LAST_IDX);

  // R2
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> idx_q == '0);

  // R7
  step_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (step_i && !clear_i) |=> idx_q == BEAT_BITS'($past(idx_q) + ONE));

  // R8
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (last_o && step_i && !clear_i) |=> idx_q == '0);
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int BEAT_BITS = 2
) (
  input  order_e               mode_i,
  input  logic [BEAT_BITS-1:0] start_i,
  input  logic [BEAT_BITS-1:0] idx_i,
  output logic [BEAT_BITS-1:0] low_o
);
  always_comb begin
    case (mode_i)
      ORD_INTERLEAVE: low_o = start_i ^ idx_i;
      default:        low_o = start_i + idx_i;
    endcase
  end

  // R2
  always_comb begin
    beat0_chk: assert (idx_i != '0 || low_o == start_i);
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BEAT_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              advance_i,
  input  logic              mode_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  localparam int HI_W = ADDR_W - BEAT_BITS;

  logic [ADDR_W-1:0]    base_q;
  order_e               mode_q;
  logic [BEAT_BITS-1:0] idx;
  logic [BEAT_BITS-1:0] low;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      mode_q <= ORD_LINEAR;
    end else if (load_i) begin
      base_q <= start_addr_i;
      mode_q <= order_e'(mode_i);
    end
  end

  burst_beat_counter #(.BEAT_BITS(BEAT_BITS)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .clear_i (load_i),
    .step_i  (advance_i),
    .idx_o   (idx),
    .last_o  (last_o)
  );

  burst_order_map #(.BEAT_BITS(BEAT_BITS)) u_map (
    .mode_i  (mode_q),
    .start_i (base_q[BEAT_BITS-1:0]),
    .idx_i   (idx),
    .low_o   (low)
  );

  assign addr_o = {base_q[ADDR_W-1:BEAT_BITS], low};

  // R2
  load_addr_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> addr_o == $past(start_addr_i));

  // R3
  upper_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> addr_o[ADDR_W-1:BEAT_BITS] == $past(addr_o[ADDR_W-1:BEAT_BITS]));

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(mode_q));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !advance_i) |=> ($stable(addr_o) && $stable(last_o)));

  // R8
  wrap_start_chk: assert property (@(posedge clk) disable iff (rst)
    (last_o && advance_i && !load_i) |=> addr_o == base_q);

  initial begin
    hi_width_chk: assert (HI_W >= 0);
  end
endmodule

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          load_i;
  logic [AW-1:0] start_addr_i;
  logic          advance_i;
  logic          mode_i;
  logic [AW-1:0] addr_o;
  logic          last_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BEAT_BITS(2)) dut (
    .clk(clk), .rst(rst), .load_i(load_i), .start_addr_i(start_addr_i),
    .advance_i(advance_i), .mode_i(mode_i), .addr_o(addr_o), .last_o(last_o)
  );

  // {mode, start, beat0, beat1, beat2, beat3}
  localparam logic [10:0] VEC [8] = '{
    {1'b0, 2'b00, 2'b00, 2'b01, 2'b10, 2'b11},
    {1'b0, 2'b01, 2'b01, 2'b10, 2'b11, 2'b00},
    {1'b0, 2'b10, 2'b10, 2'b11, 2'b00, 2'b01},
    {1'b0, 2'b11, 2'b11, 2'b00, 2'b01, 2'b10},
    {1'b1, 2'b00, 2'b00, 2'b01, 2'b10, 2'b11},
    {1'b1, 2'b01, 2'b01, 2'b00, 2'b11, 2'b10},
    {1'b1, 2'b10, 2'b10, 2'b11, 2'b00, 2'b01},
    {1'b1, 2'b11, 2'b11, 2'b10, 2'b01, 2'b00}
  };

  task automatic chk(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_load(logic [AW-1:0] a, logic m, logic adv);
    load_i = 1'b1; start_addr_i = a; mode_i = m; advance_i = adv;
    tick();
    load_i = 1'b0; advance_i = 1'b0;
  endtask

  task automatic do_adv();
    advance_i = 1'b1;
    tick();
    advance_i = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; load_i = 1'b0; advance_i = 1'b0; mode_i = 1'b0;
    start_addr_i = '0;
    @(negedge clk); tick(); tick();
    rst = 1'b0;
    // R1 reset state
    chk("R1 addr", addr_o, '0);
    chk("R1 last", {31'b0, last_o}, 32'd0);

    // Vector walk: R3, R4, R5, R6, R9, R8
    for (int v = 0; v < 8; v++) begin
      logic [AW-1:0] base;
      logic [1:0]    exp_low [4];
      base = 32'h5A00_0000 | (AW'(v) << 12) | AW'(VEC[v][9:8]);
      exp_low[0] = VEC[v][7:6]; exp_low[1] = VEC[v][5:4];
      exp_low[2] = VEC[v][3:2]; exp_low[3] = VEC[v][1:0];
      do_load(base, VEC[v][10], 1'b0);
      for (int b = 0; b < 4; b++) begin
        chk(VEC[v][10] ? "R5 R3 beat addr" : "R4 R3 beat addr",
            addr_o, {base[AW-1:2], exp_low[b]});
        chk("R9 last", {31'b0, last_o}, {31'b0, (b == 3)});
        if (b < 3) do_adv();
      end
      do_adv();
      chk("R8 wrap to start", addr_o, base);
    end

    // R6 start 00 agrees in both modes
    for (int m = 0; m < 2; m++) begin
      do_load(32'h0000_1230, m[0], 1'b0);
      for (int b = 0; b < 4; b++) begin
        chk("R6 zero start", addr_o, 32'h0000_1230 | AW'(b));
        do_adv();
      end
    end

    // R2 full address capture, R7 idle hold
    do_load(32'hFFFF_FFFE, 1'b1, 1'b0);
    chk("R2 load", addr_o, 32'hFFFF_FFFE);
    tick(); tick();
    chk("R7 idle hold", addr_o, 32'hFFFF_FFFE);
    do_adv();
    chk("R7 advance", addr_o, 32'hFFFF_FFFF);
    tick();
    chk("R7 idle hold after step", addr_o, 32'hFFFF_FFFF);

    // R10 mode change mid-burst ignored (linear start 01)
    do_load(32'h0000_0041, 1'b0, 1'b0);
    mode_i = 1'b1;
    do_adv();
    chk("R10 beat1", addr_o, 32'h0000_0042);
    mode_i = 1'b0; mode_i = 1'b1;
    do_adv();
    chk("R10 beat2", addr_o, 32'h0000_0043);
    do_adv();
    chk("R10 beat3", addr_o, 32'h0000_0040);

    // R11 load beats advance
    do_adv();
    do_load(32'h0000_0082, 1'b1, 1'b1);
    chk("R11 load wins", addr_o, 32'h0000_0082);
    chk("R11 beat zero last", {31'b0, last_o}, 32'd0);
    do_adv();
    chk("R11 next beat", addr_o, 32'h0000_0083);

    // R1 reset mid-burst
    do_adv(); do_adv();
    rst = 1'b1; tick(); rst = 1'b0;
    chk("R1 reset addr", addr_o, '0);
    chk("R1 reset last", {31'b0, last_o}, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule